// File: doc/BRIEF.md
# UART Receive Holding Queue with Per-Character Status

This block sits behind the bit-level deserializer of an asynchronous serial receiver. Each time the deserializer finishes a frame it raises a one-cycle strobe together with the data bits, the parity bit it sampled and a flag saying whether the stop bit was good. The block checks parity, then stores the character in a small first-in first-out queue. Each stored entry carries its own parity-error, frame-error and overrun flags.

The host sees only the entry at the head of the queue. The data and all three flags shown on the read side always describe that one character. The host pops it with a one-cycle read strobe. If a frame completes while the queue is full and no pop happens in the same cycle, that frame is lost. The newest stored character is then marked as overrun, so the host learns about the loss exactly when it reads the character that came just before the gap. Dropping the receive enable discards frames at once and empties the queue in the next cycle.

Top module: `uart_rx_holdq`

## Requirements
- R1: When `par_chk` is 0 as a frame is accepted, that character's parity-error flag is stored as 0, whatever its parity bit.
- R2: When `par_chk` is 1, `par_odd` selects the check. With `par_odd` = 1 the count of ones in the data bits plus the parity bit must be odd; with `par_odd` = 0 it must be even. A character that breaks this rule shows `rd_perr` = 1.
- R3: A character received with `frm_stop_ok` = 0 shows `rd_ferr` = 1 when it reaches the head; with `frm_stop_ok` = 1 it shows 0.
- R4: Characters come out in arrival order. `rd_data`, `rd_perr`, `rd_ferr` and `rd_ovr` always describe the current head entry and change only when that entry is popped.
- R5: `rd_avail` is 1 in the cycle after a frame is accepted and stays 1 while any unread character remains. Popping until it clears empties the queue, which holds DEPTH (default 2) characters.
- R6: A frame that arrives while the queue is full, with no pop in the same cycle, is dropped, and the newest stored entry gets overrun = 1. Entries stored before it keep overrun = 0.
- R7: While `rx_on` is 0, strobed frames are ignored. One cycle after `rx_on` is seen low, `rd_avail` is 0 and every unread character is gone.
- R8: A pop while the queue is empty moves no pointer. `rd_data` then keeps showing the last popped character (0 after reset), with all flags 0.
- R9: A frame that arrives while the queue is full, in the same cycle as a pop, is accepted; no overrun is recorded.
- R10: After reset `rd_avail`, `rd_data` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_on | input | 1 | Receive enable; low flushes and blocks the queue |
| par_chk | input | 1 | Parity checking on when 1 |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | DATA_W | Received data bits |
| frm_par | input | 1 | Received parity bit |
| frm_stop_ok | input | 1 | 1 when the stop bit was sampled high |
| rd_pop | input | 1 | Host read strobe: pop the head character |
| rd_data | output | DATA_W | Head character, or last popped character when empty |
| rd_avail | output | 1 | At least one unread character is queued |
| rd_perr | output | 1 | Parity error of the head character |
| rd_ferr | output | 1 | Stop-bit error of the head character |
| rd_ovr | output | 1 | A frame was lost right after the head character |

## Verification
The assertions assume that `frm_valid` and `rd_pop` are ordinary synchronous single-cycle strobes with known values, and that the control inputs are stable around the clock edge. They also assume a frame strobe may coincide with a pop, with an empty queue or with `rx_on` low, and all of those cases are defined. The stimulus drives every input on the falling edge from a fixed-seed random source. Frames come about 40% of the cycles, pops about 40%, and short enable drops about 3%. This sits beside directed runs for overrun, same-cycle push-and-pop when full, flushing and empty reads. Every value driven stays known, so no check has to reason about unknown states.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   typedef struct packed {
      logic perr;
      logic ferr;
      logic ovr;
   } rxq_flags_t;

   localparam rxq_flags_t RXQ_FLAGS_CLEAR = '{perr: 1'b0, ferr: 1'b0, ovr: 1'b0};

   // 1 when the number of ones in the word plus the extra bit is odd
   function automatic logic odd_weight(input logic [63:0] word, input logic extra);
      return (^word) ^ extra;
   endfunction

endpackage

// File: rtl/rxq_parity.sv
module rxq_parity
   import uart_rxq_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              chk_en,
   input  logic              odd_sel,
   input  logic [DATA_W-1:0] data,
   input  logic              par_bit,
   input  logic              stop_ok,
   output rxq_flags_t        flags
);

   logic perr;

   generate
      if (PARITY_SUPPORT) begin : g_check
         logic weight_odd;
         assign weight_odd = odd_weight(64'(data), par_bit);
         // error when observed weight differs from selected parity sense
         assign perr = chk_en & (weight_odd ^ odd_sel);
      end else begin : g_none
         logic unused_in;
         assign unused_in = chk_en ^ odd_sel ^ par_bit ^ (^data);
         assign perr = 1'b0;
      end
   endgenerate

   always_comb begin
      flags      = RXQ_FLAGS_CLEAR;
      flags.perr = perr;
      flags.ferr = ~stop_ok;
   end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import uart_rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  rxq_flags_t        push_flg,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output rxq_flags_t        head_flg,
   output logic              empty,
   output logic              pop_fire
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "rxq_store: DEPTH must be a power of two, at least 2");
      if (DATA_W < 1 || DATA_W > 64)
         $fatal(1, "rxq_store: DATA_W must be 1..64");
   end

   logic [DATA_W-1:0] mem_d [DEPTH];
   rxq_flags_t        mem_f [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic              full, push_fire, drop;

   assign full      = (count == CNT_FULL);
   assign empty     = (count == '0);
   assign pop_fire  = en & pop & ~empty;
   assign push_fire = en & push & (~full | pop);
   assign drop      = en & push & full & ~pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] <= '0;
            mem_f[i] <= RXQ_FLAGS_CLEAR;
         end
      end else if (!en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_fire) begin
            mem_d[wr_ptr] <= push_data;
            mem_f[wr_ptr] <= push_flg;
            wr_ptr        <= wr_ptr + 1'b1;
         end
         if (drop)
            mem_f[wr_ptr - 1'b1].ovr <= 1'b1;
         if (pop_fire)
            rd_ptr <= rd_ptr + 1'b1;
         case ({push_fire, pop_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_data = mem_d[rd_ptr];
   assign head_flg  = mem_f[rd_ptr];

endmodule

// File: rtl/rxq_readout.sv
module rxq_readout
   import uart_rxq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] head_data,
   input  rxq_flags_t        head_flg,
   input  logic              empty,
   input  logic              pop_fire,
   output logic [DATA_W-1:0] out_data,
   output rxq_flags_t        out_flg,
   output logic              avail
);

   logic [DATA_W-1:0] last_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_data <= '0;
      else if (pop_fire)
         last_data <= head_data;
   end

   assign avail    = ~empty;
   assign out_data = empty ? last_data : head_data;
   assign out_flg  = empty ? RXQ_FLAGS_CLEAR : head_flg;

endmodule

// File: rtl/uart_rx_holdq.sv
module uart_rx_holdq
   import uart_rxq_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 2,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_on,
   input  logic              par_chk,
   input  logic              par_odd,
   input  logic              frm_valid,
   input  logic [DATA_W-1:0] frm_data,
   input  logic              frm_par,
   input  logic              frm_stop_ok,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail,
   output logic              rd_perr,
   output logic              rd_ferr,
   output logic              rd_ovr
);

   rxq_flags_t        in_flg, head_flg, out_flg;
   logic [DATA_W-1:0] head_data;
   logic              empty, pop_fire;

   rxq_parity #(.DATA_W(DATA_W), .PARITY_SUPPORT(PARITY_SUPPORT)) u_par (
      .chk_en  (par_chk),
      .odd_sel (par_odd),
      .data    (frm_data),
      .par_bit (frm_par),
      .stop_ok (frm_stop_ok),
      .flags   (in_flg)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_on),
      .push      (frm_valid),
      .push_data (frm_data),
      .push_flg  (in_flg),
      .pop       (rd_pop),
      .head_data (head_data),
      .head_flg  (head_flg),
      .empty     (empty),
      .pop_fire  (pop_fire)
   );

   rxq_readout #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .head_data (head_data),
      .head_flg  (head_flg),
      .empty     (empty),
      .pop_fire  (pop_fire),
      .out_data  (rd_data),
      .out_flg   (out_flg),
      .avail     (rd_avail)
   );

   assign rd_perr = out_flg.perr;
   assign rd_ferr = out_flg.ferr;
   assign rd_ovr  = out_flg.ovr;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_on,
   input logic              par_chk,
   input logic              frm_valid,
   input logic              rd_pop,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_avail,
   input logic              rd_perr,
   input logic              rd_ferr,
   input logic              rd_ovr
);

   AST_FLUSH_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_on |=> !rd_avail); // R7

   AST_FILL_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && frm_valid && !rd_avail) |=> rd_avail); // R5

   AST_NO_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on && frm_valid && !par_chk && !rd_avail) |=> !rd_perr); // R1

   AST_EMPTY_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_avail |-> (!rd_perr && !rd_ferr && !rd_ovr)); // R8

   AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_avail && rd_pop && !frm_valid) |=> $stable(rd_data)); // R8

endmodule

bind uart_rx_holdq rxq_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_on     (rx_on),
   .par_chk   (par_chk),
   .frm_valid (frm_valid),
   .rd_pop    (rd_pop),
   .rd_data   (rd_data),
   .rd_avail  (rd_avail),
   .rd_perr   (rd_perr),
   .rd_ferr   (rd_ferr),
   .rd_ovr    (rd_ovr)
);

// File: tb/uart_rx_holdq_test.sv
`timescale 1ns/1ps
module uart_rx_holdq_test;

   localparam int DW    = 8;
   localparam int DEPTH = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_on = 1'b0, par_chk = 1'b0, par_odd = 1'b0;
   logic          frm_valid = 1'b0, frm_par = 1'b0, frm_stop_ok = 1'b1, rd_pop = 1'b0;
   logic [DW-1:0] frm_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_avail, rd_perr, rd_ferr, rd_ovr;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   uart_rx_holdq #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .par_chk(par_chk), .par_odd(par_odd),
      .frm_valid(frm_valid), .frm_data(frm_data), .frm_par(frm_par),
      .frm_stop_ok(frm_stop_ok), .rd_pop(rd_pop), .rd_data(rd_data),
      .rd_avail(rd_avail), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_ovr(rd_ovr)
   );

   typedef struct packed {
      logic [DW-1:0] d;
      logic pe, fe, ov;
   } ent_t;

   ent_t          mq[$];
   logic [DW-1:0] m_last = '0;

   function automatic logic exp_perr(input logic chk, input logic odd,
                                     input logic [DW-1:0] d, input logic p);
      int ones;
      ones = $countones(d) + int'(p);
      return chk && ((ones % 2) != int'(odd));
   endfunction

   task automatic compare(input string tag);
      logic [DW-1:0] ed;
      logic ea, ep, ef, eo;
      ea = (mq.size() > 0);
      ed = ea ? mq[0].d : m_last;
      ep = ea ? mq[0].pe : 1'b0;
      ef = ea ? mq[0].fe : 1'b0;
      eo = ea ? mq[0].ov : 1'b0;
      checks++;
      if (rd_avail !== ea || rd_data !== ed || rd_perr !== ep || rd_ferr !== ef || rd_ovr !== eo) begin
         fails++;
         $display("FAIL %s: avail/data/pe/fe/ov = %0b/%02h/%0b/%0b/%0b expected %0b/%02h/%0b/%0b/%0b",
                  tag, rd_avail, rd_data, rd_perr, rd_ferr, rd_ovr, ea, ed, ep, ef, eo);
      end
   endtask

   // drive at falling edge, model the rising edge, compare at next falling edge
   task automatic step(input string tag, input logic en, input logic chk, input logic odd,
                       input logic v, input logic [DW-1:0] d, input logic p,
                       input logic s, input logic pop);
      logic full;
      rx_on = en; par_chk = chk; par_odd = odd; frm_valid = v;
      frm_data = d; frm_par = p; frm_stop_ok = s; rd_pop = pop;
      @(posedge clk);
      if (!en) begin
         mq.delete();
      end else begin
         full = (mq.size() == DEPTH);
         if (pop && mq.size() > 0) begin
            m_last = mq[0].d;
            void'(mq.pop_front());
         end
         if (v) begin
            if (full && !pop) mq[mq.size()-1].ov = 1'b1;
            else mq.push_back('{d: d, pe: exp_perr(chk, odd, d, p), fe: ~s, ov: 1'b0});
         end
      end
      @(negedge clk);
      compare(tag);
   endtask

   task automatic rx(input string tag, input logic chk, input logic odd,
                     input logic [DW-1:0] d, input logic p, input logic s);
      step(tag, 1'b1, chk, odd, 1'b1, d, p, s, 1'b0);
   endtask

   task automatic rd(input string tag);
      step(tag, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
   endtask

   initial begin
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      compare("R10 reset state");
      rst_n = 1'b1;
      idle("R10 idle after reset");

      // R8: empty pop after reset leaves data 0 and flags 0
      rd("R8 empty pop");
      rx("R5 first frame", 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1);
      rd("R4 pop first");
      rd("R8 empty pop keeps last data");

      // R1: parity off, wrong parity stored as clean
      rx("R1 parity off", 1'b0, 1'b1, 8'h01, 1'b1, 1'b1);
      rd("R1 pop");

      // R2: even and odd sense
      rx("R2 even good", 1'b1, 1'b0, 8'h03, 1'b0, 1'b1);
      rx("R2 even bad",  1'b1, 1'b0, 8'h03, 1'b1, 1'b1);
      rd("R2 pop even good");
      rd("R2 pop even bad");
      rx("R2 odd good", 1'b1, 1'b1, 8'h01, 1'b0, 1'b1);
      rx("R2 odd bad",  1'b1, 1'b1, 8'h01, 1'b1, 1'b1);
      rd("R2 pop odd good");
      rd("R2 pop odd bad");

      // R3: stop error
      rx("R3 bad stop", 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0);
      rd("R3 pop");

      // R6: overrun on full queue
      rx("R6 fill 1", 1'b0, 1'b0, 8'h11, 1'b0, 1'b1);
      rx("R6 fill 2", 1'b0, 1'b0, 8'h22, 1'b0, 1'b1);
      rx("R6 lost frame", 1'b0, 1'b0, 8'h33, 1'b0, 1'b1);
      rd("R6 first entry no overrun");
      rd("R6 second entry overrun");
      rd("R6 drained");

      // R9: full with push and pop in the same cycle
      rx("R9 fill 1", 1'b0, 1'b0, 8'h44, 1'b0, 1'b1);
      rx("R9 fill 2", 1'b0, 1'b0, 8'h55, 1'b0, 1'b1);
      step("R9 push with pop", 1'b1, 1'b0, 1'b0, 1'b1, 8'h66, 1'b0, 1'b1, 1'b1);
      rd("R9 pop 55");
      rd("R9 pop 66");

      // R7: disable flushes and ignores frames
      rx("R7 fill 1", 1'b0, 1'b0, 8'h77, 1'b0, 1'b1);
      rx("R7 fill 2", 1'b0, 1'b0, 8'h88, 1'b0, 1'b1);
      step("R7 disable with frame", 1'b0, 1'b0, 1'b0, 1'b1, 8'h99, 1'b0, 1'b1, 1'b0);
      step("R7 disabled pop", 1'b0, 1'b0, 1'b0, 1'b1, 8'h9A, 1'b0, 1'b1, 1'b1);
      idle("R7 re-enabled empty");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic en, v, pop, chk, odd, p, s;
         logic [DW-1:0] d;
         en  = ($urandom % 100) >= 3;
         v   = ($urandom % 100) < 40;
         pop = ($urandom % 100) < 40;
         chk = $urandom % 2;
         odd = $urandom % 2;
         p   = $urandom % 2;
         s   = ($urandom % 8) != 0;
         d   = DW'($urandom);
         step("R4 random", en, chk, odd, v, d, p, s, pop);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule